// File: doc/BRIEF.md
# Load/store multiple sequencer

The sequencer accepts one multi-register transfer command and breaks it into single-word memory accesses, one register at a time. A command carries a base address, a register-select mask, a load/store flag, an addressing mode and a writeback flag. For each selected register the block presents the register index, the word address and the direction on a valid/ready memory port. Store data comes from a register-file read port addressed by the current index. Load data returned by memory is written to the register file in the cycle the access is accepted.

Two modes exist. In increment-after mode (mode bit 0, the default) registers go out in ascending index order and addresses climb from the base. In decrement-before mode (mode bit 1) registers go out in descending index order and addresses fall from the base. The word count is the population count of the mask, taken when the command is accepted. It fixes the final address, and that address can be written back to a chosen base register after the last access.

Top module: `lsm_seq`

## Requirements
- R1: Consecutive accesses of one command are exactly DW/8 (4) bytes apart, and every access moves one DW-bit word.
- R2: With cmd_mode_i = 0 (increment-after), selected registers are accessed in increasing index order. The k-th access (k counted from 0) uses address base + 4*k, so the lowest selected register sits at base and the last access is at base + 4*(n-1).
- R3: With cmd_mode_i = 1 (decrement-before), selected registers are accessed in decreasing index order. The k-th access uses address base - 4*k, so the highest selected register sits at base and the lowest is at base - 4*(n-1).
- R4: With cmd_wb_i = 1, exactly one register-file write follows the last access, with no memory request active. It writes base + 4*(n-1) (mode 0) or base - 4*(n-1) (mode 1) to index cmd_base_reg_i. With cmd_wb_i = 0 no such write occurs.
- R5: For a load (cmd_load_i = 1, mem_we_o = 0), each accepted access writes mem_rdata_i to register mem_idx_o in that same cycle.
- R6: For a store (cmd_load_i = 0, mem_we_o = 1), rf_raddr_o equals the access index and mem_wdata_o equals rf_rdata_i; the register file is not written during the accesses.
- R7: A command with an all-zero mask is rejected. err_o is high for one cycle, in the cycle after acceptance. No memory access, no writeback and no done_o follow.
- R8: cmd_ready_o is high only while the block is idle, and no memory request is active while it is high. Commands offered while the block is busy are ignored and do not disturb the running sequence.
- R9: A request with mem_ready_i low is held unchanged (index, address, direction) until mem_ready_i is seen high.
- R10: done_o is a one-cycle pulse. It appears in the cycle after the last access is accepted, or in the cycle after the writeback cycle if writeback was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command taken when valid |
| cmd_base_i | input | AW | Base address |
| cmd_mask_i | input | NREG | Register-select mask |
| cmd_load_i | input | 1 | 1 = load from memory, 0 = store |
| cmd_mode_i | input | 1 | 0 = increment-after, 1 = decrement-before |
| cmd_wb_i | input | 1 | Write final address back to base register |
| cmd_base_reg_i | input | IW | Index of base register for writeback |
| mem_req_o | output | 1 | Memory access valid |
| mem_ready_i | input | 1 | Memory accepts access (read data valid) |
| mem_we_o | output | 1 | 1 = write to memory |
| mem_addr_o | output | AW | Word address (byte units) |
| mem_idx_o | output | IW | Register index of current access |
| mem_wdata_o | output | DW | Store data |
| mem_rdata_i | input | DW | Load data, valid with mem_ready_i |
| rf_raddr_o | output | IW | Register-file read index |
| rf_rdata_i | input | DW | Register-file read data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | IW | Register-file write index |
| rf_wdata_o | output | DW | Register-file write data |
| done_o | output | 1 | Command finished pulse |
| err_o | output | 1 | Empty-mask rejection pulse |

## Verification
The bench runs an 8-register instance over every mask value in both modes, both directions and both writeback settings. The all-zero mask separates rejection from a normal run. Single-bit masks separate the start address from the step, and sparse and full masks check that the priority walk skips holes in the right direction. The memory ready signal follows a pseudo-random pattern, so stalls land on first, middle and last accesses. Some commands are offered while the block is busy, which shows whether anything leaks into the running sequence.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WB   = 2'd2
  } lsm_state_e;

  typedef enum logic {
    MODE_INC_AFTER  = 1'b0,
    MODE_DEC_BEFORE = 1'b1
  } lsm_mode_e;
endpackage

// File: rtl/lsm_pick.sv
// Priority pick over remaining mask: lowest set bit when incrementing, highest when decrementing.
module lsm_pick #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask_i,
  input  logic            dec_i,
  output logic [IW-1:0]   idx_o,
  output logic [NREG-1:0] onehot_o
);
  always_comb begin
    idx_o = '0;
    if (dec_i) begin
      for (int i = 0; i < NREG; i++) if (mask_i[i]) idx_o = IW'(i);
    end else begin
      for (int i = NREG - 1; i >= 0; i--) if (mask_i[i]) idx_o = IW'(i);
    end
    onehot_o = NREG'(1) << idx_o;
  end
endmodule

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int N = 16,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/lsm_wbcalc.sv
// Final address: base +/- STEP*(n-1).
module lsm_wbcalc #(
  parameter int AW   = 32,
  parameter int CW   = 5,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          dec_i,
  output logic [AW-1:0] wb_o
);
  logic [AW-1:0] off;
  always_comb begin
    off  = (AW'(cnt_i) - AW'(1)) * AW'(STEP);
    wb_o = dec_i ? base_i - off : base_i + off;
  end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  output logic            cmd_ready_o,
  input  logic [AW-1:0]   cmd_base_i,
  input  logic [NREG-1:0] cmd_mask_i,
  input  logic            cmd_load_i,
  input  logic            cmd_mode_i,
  input  logic            cmd_wb_i,
  input  logic [IW-1:0]   cmd_base_reg_i,
  output logic            mem_req_o,
  input  logic            mem_ready_i,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [IW-1:0]   mem_idx_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [IW-1:0]   rf_raddr_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [IW-1:0]   rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int CW   = $clog2(NREG + 1);
  localparam int STEP = DW / 8;
  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  lsm_state_e      state_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q, wbval_q, wbval_d;
  logic            dec_q, load_q, wb_q, done_q, err_q;
  logic [IW-1:0]   breg_q, cur_idx;
  logic [NREG-1:0] cur_oh;
  logic [CW-1:0]   cmd_cnt;
  logic            fire, last, in_wb;

  lsm_pick #(.NREG(NREG)) u_pick (
    .mask_i  (rem_q),
    .dec_i   (dec_q),
    .idx_o   (cur_idx),
    .onehot_o(cur_oh)
  );

  lsm_popcnt #(.N(NREG)) u_cnt (
    .vec_i(cmd_mask_i),
    .cnt_o(cmd_cnt)
  );

  lsm_wbcalc #(.AW(AW), .CW(CW), .STEP(STEP)) u_wb (
    .base_i(cmd_base_i),
    .cnt_i (cmd_cnt),
    .dec_i (cmd_mode_i),
    .wb_o  (wbval_d)
  );

  assign fire  = (state_q == ST_XFER) && mem_ready_i;
  assign last  = (rem_q & ~cur_oh) == '0;
  assign in_wb = (state_q == ST_WB);

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_XFER);
  assign mem_we_o    = ~load_q;
  assign mem_addr_o  = addr_q;
  assign mem_idx_o   = cur_idx;
  assign rf_raddr_o  = cur_idx;
  assign mem_wdata_o = rf_rdata_i;
  assign rf_we_o     = (fire && load_q) || in_wb;
  assign rf_waddr_o  = in_wb ? breg_q : cur_idx;
  assign rf_wdata_o  = in_wb ? wbval_q : mem_rdata_i;
  assign done_o      = done_q;
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      wbval_q <= '0;
      breg_q  <= '0;
      dec_q   <= 1'b0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid_i) begin
            if (cmd_mask_i == '0) begin
              err_q <= 1'b1;
            end else begin
              state_q <= ST_XFER;
              rem_q   <= cmd_mask_i;
              addr_q  <= cmd_base_i;
              wbval_q <= wbval_d;
              breg_q  <= cmd_base_reg_i;
              dec_q   <= (cmd_mode_i == MODE_DEC_BEFORE);
              load_q  <= cmd_load_i;
              wb_q    <= cmd_wb_i;
            end
          end
        end
        ST_XFER: begin
          if (fire) begin
            rem_q  <= rem_q & ~cur_oh;
            addr_q <= dec_q ? addr_q - STEP_A : addr_q + STEP_A;
            if (last) begin
              state_q <= wb_q ? ST_WB : ST_IDLE;
              done_q  <= ~wb_q;
            end
          end
        end
        ST_WB: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_ready_o,
  input logic          mem_req_o,
  input logic          mem_ready_i,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [IW-1:0] mem_idx_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic [DW-1:0] mem_rdata_i,
  input logic [IW-1:0] rf_raddr_o,
  input logic [DW-1:0] rf_rdata_i,
  input logic          rf_we_o,
  input logic [IW-1:0] rf_waddr_o,
  input logic [DW-1:0] rf_wdata_o,
  input logic          done_o,
  input logic          err_o
);
  localparam logic [AW-1:0] STEP_A = AW'(DW / 8);

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i |=> !mem_req_o ||
      mem_addr_o == $past(mem_addr_o) + STEP_A || mem_addr_o == $past(mem_addr_o) - STEP_A);

  p_load_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i && !mem_we_o |->
      rf_we_o && rf_waddr_o == mem_idx_o && rf_wdata_o == mem_rdata_i);

  p_store_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !rf_we_o && rf_raddr_o == mem_idx_o && mem_wdata_o == rf_rdata_i);

  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> cmd_ready_o && !mem_req_o && !done_o && !rf_we_o);

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !mem_req_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_idx_o) && $stable(mem_we_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o && !rf_we_o);
endmodule

bind lsm_seq lsm_seq_chk #(.NREG(NREG), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/lsm_seq_tb_top.sv
module lsm_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IW = $clog2(NREG);

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cmd_valid_i = 1'b0;
  logic            cmd_ready_o;
  logic [AW-1:0]   cmd_base_i = '0;
  logic [NREG-1:0] cmd_mask_i = '0;
  logic            cmd_load_i = 1'b0;
  logic            cmd_mode_i = 1'b0;
  logic            cmd_wb_i = 1'b0;
  logic [IW-1:0]   cmd_base_reg_i = '0;
  logic            mem_req_o, mem_we_o, rf_we_o, done_o, err_o;
  logic            mem_ready_i = 1'b0;
  logic [AW-1:0]   mem_addr_o;
  logic [IW-1:0]   mem_idx_o, rf_raddr_o, rf_waddr_o;
  logic [DW-1:0]   mem_wdata_o, mem_rdata_i, rf_rdata_i, rf_wdata_o;
  logic [15:0]     salt = 16'h1234;
  logic [15:0]     lfsr = 16'hACE1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Arithmetic memory and register-file models
  assign mem_rdata_i = {salt, mem_addr_o[15:0]};
  assign rf_rdata_i  = {~salt, 13'd0, rf_raddr_o};

  lsm_seq #(.NREG(NREG), .AW(AW), .DW(DW)) dut_i (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;
  always @(posedge clk_i) cycles <= cycles + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [NREG-1:0] mask, input bit dec, input bit load,
                         input bit wb, input bit noise);
    logic [AW-1:0] base, wbv;
    logic [IW-1:0] breg;
    int n, k, t_last, t_wb, t_done, t_err, wb_cnt;
    int order [NREG];
    bit stall_prev;
    logic [AW-1:0] p_addr;
    logic [IW-1:0] p_idx;
    base = (dec ? 32'h0000_C000 : 32'h0000_4000) + {20'd0, mask, 4'd0};
    breg = mask[IW-1:0] ^ IW'(5);
    n = 0;
    if (dec) begin
      for (int i = NREG - 1; i >= 0; i--) if (mask[i]) begin order[n] = i; n++; end
    end else begin
      for (int i = 0; i < NREG; i++) if (mask[i]) begin order[n] = i; n++; end
    end
    wbv = dec ? base - 32'(4 * (n - 1)) : base + 32'(4 * (n - 1));
    salt = salt + 16'h0101;

    @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R8 ready when idle", cmd_ready_o, 1);
    cmd_valid_i = 1'b1; cmd_base_i = base; cmd_mask_i = mask; cmd_load_i = load;
    cmd_mode_i = dec; cmd_wb_i = wb; cmd_base_reg_i = breg;
    @(posedge clk_i); #1;
    if (noise && n > 0) begin
      cmd_valid_i = 1'b1; cmd_mask_i = ~mask; cmd_base_i = 32'h0000_0F00;
      cmd_mode_i = ~dec; cmd_load_i = ~load; cmd_wb_i = 1'b1;
    end else cmd_valid_i = 1'b0;

    k = 0; t_last = -1; t_wb = -1; t_done = -1; t_err = -1; wb_cnt = 0;
    stall_prev = 1'b0; p_addr = '0; p_idx = '0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk_i);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready_i = lfsr[0] | lfsr[5];
      #1;
      if (stall_prev) begin
        chk(mem_req_o && mem_addr_o == p_addr && mem_idx_o == p_idx, "R9 held while stalled",
            mem_addr_o, p_addr);
      end
      if (mem_req_o) chk(!cmd_ready_o, "R8 busy not ready", cmd_ready_o, 0);
      if (mem_req_o) begin
        if (k >= n) begin
          chk(1'b0, dec ? "R3 extra access" : "R2 extra access", k, n);
        end else if (mem_ready_i) begin
          chk(mem_idx_o == IW'(order[k]), dec ? "R3 index order" : "R2 index order",
              mem_idx_o, order[k]);
          chk(mem_addr_o == (dec ? base - 32'(4 * k) : base + 32'(4 * k)),
              dec ? "R3 address (R1 step)" : "R2 address (R1 step)", mem_addr_o,
              dec ? base - 32'(4 * k) : base + 32'(4 * k));
          chk(mem_we_o == !load, "R5/R6 direction", mem_we_o, !load);
          if (load) begin
            chk(rf_we_o && rf_waddr_o == IW'(order[k]) &&
                rf_wdata_o == {salt, mem_addr_o[15:0]}, "R5 load write", rf_wdata_o,
                {salt, mem_addr_o[15:0]});
          end else begin
            chk(!rf_we_o && mem_wdata_o == {~salt, 13'd0, IW'(order[k])}, "R6 store data",
                mem_wdata_o, {~salt, 13'd0, IW'(order[k])});
          end
          if (k == n - 1) begin
            t_last = t;
            cmd_valid_i = 1'b0;
          end
          k++;
        end
        stall_prev = !mem_ready_i; p_addr = mem_addr_o; p_idx = mem_idx_o;
      end else begin
        stall_prev = 1'b0;
      end
      if (!mem_req_o && rf_we_o) begin
        wb_cnt++; t_wb = t;
        chk(rf_waddr_o == breg && rf_wdata_o == wbv, "R4 writeback value", rf_wdata_o, wbv);
      end
      if (err_o) begin t_err = t; break; end
      if (done_o) begin t_done = t; break; end
    end

    if (n == 0) begin
      chk(t_err == 0, "R7 err timing", t_err, 0);
      chk(k == 0 && wb_cnt == 0 && t_done < 0, "R7 no activity", k, 0);
    end else begin
      chk(t_err < 0, "R7 no err on valid mask", t_err, -1);
      chk(k == n, dec ? "R3 access count" : "R2 access count", k, n);
      chk(wb_cnt == (wb ? 1 : 0), "R4 writeback count", wb_cnt, wb ? 1 : 0);
      if (wb) chk(t_wb == t_last + 1, "R4 writeback timing", t_wb, t_last + 1);
      chk(t_done == (wb ? t_last + 2 : t_last + 1), "R10 done timing", t_done,
          wb ? t_last + 2 : t_last + 1);
    end
    @(negedge clk_i); #1;
    chk(!done_o && !err_o, "R10 single-cycle pulse", done_o, 0);
    chk(cmd_ready_o && !mem_req_o, "R8 idle after command", cmd_ready_o, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk(cmd_ready_o && !mem_req_o && !done_o && !err_o && !rf_we_o, "R8 reset state",
        {cmd_ready_o, mem_req_o, done_o, err_o, rf_we_o}, 5'b10000);
    rst_ni = 1'b1;
    for (int m = 0; m < (1 << NREG); m++) begin
      for (int c = 0; c < 8; c++) begin
        run_cmd(NREG'(m), c[0], c[1], c[2], (m % 3) == 0);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule